// File: doc/BRIEF.md
# Key Wake-Up Interrupt Latch

This block turns a falling edge on an asynchronous, idle-high wake-up line into an interrupt request for a processor. The raw line passes through a synchronizer. A falling edge seen on the synchronized value sets a pending flag, and this happens whether or not software has enabled the source. The pending flag is gated by a software enable bit. When enabled, it feeds a request latch on the processor side one clock later.

The processor-side latch holds the request until the processor acknowledges it, so a request raised while the global interrupt mask is set is kept. The take signal and the handler vector address follow the mask at once. The vector output gives the first address of the two-byte handler pointer, 0x3FF8; the second byte sits at 0x3FF9.

The enable write timing is deliberate. An edge captured while the source is disabled is kept pending. It reaches the processor latch exactly one clock after the enable bit is set. It is never dropped, and it is never passed through combinationally.

Top module: `kwi_wake_irq`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `pend_o`, `irq_req_o` and `irq_take_o` are 0 and `vec_addr_o` is 0, with `key_n_i` held high.
- R2: A high-to-low transition on `key_n_i` that stays low for at least SYNC_STAGES+1 clocks sets `pend_o` at the (SYNC_STAGES+1)-th rising edge after it is sampled. This happens regardless of `wake_en_i`.
- R3: With `wake_en_i` at 1, `irq_req_o` rises at the rising edge after the first edge at which `pend_o` is 1.
- R4: With `wake_en_i` at 0 and no acknowledge, `pend_o` stays 1 for as long as the source remains disabled, and `irq_req_o` does not rise.
- R5: If `wake_en_i` goes from 0 to 1 while `pend_o` is 1, `irq_req_o` is 1 after exactly one rising edge.
- R6: `irq_take_o` is 1 exactly when `irq_req_o` is 1 and `cpu_mask_i` is 0. `vec_addr_o` equals VEC_ADDR (default 16'h3FF8) while `irq_take_o` is 1 and is 0 otherwise.
- R7: While `cpu_mask_i` is 1, a latched `irq_req_o` stays 1 and `irq_take_o` stays 0. When the mask clears, `irq_take_o` rises in the same cycle.
- R8: An `ack_i` pulse sampled at a rising edge clears both `pend_o` and `irq_req_o` at that edge.
- R9: A falling edge that becomes visible in the same cycle as `ack_i` leaves `pend_o` set after that edge.
- R10: A low-to-high transition or a steady level on `key_n_i` never sets `pend_o`.
- R11: Once `irq_req_o` is 1, clearing `wake_en_i` does not clear it; only `ack_i` or reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_n_i | input | 1 | Raw asynchronous wake-up line, idle high |
| wake_en_i | input | 1 | Software enable for the source |
| cpu_mask_i | input | 1 | Global processor interrupt mask, 1 = masked |
| ack_i | input | 1 | Acknowledge / clear strobe from the processor |
| pend_o | output | 1 | Pending flag |
| irq_req_o | output | 1 | Processor-side latched request |
| irq_take_o | output | 1 | Request is taken (latched and unmasked) |
| vec_addr_o | output | ADDR_W | Handler vector address while taken, else 0 |

## Verification
The hardest situation to reach from the ports is a falling edge that becomes visible on the same clock as an acknowledge. The edge passes through the synchronizer and the delay stage, so the acknowledge has to be placed exactly SYNC_STAGES edges after the line is driven low. The bench creates this case deliberately with a counted delay. The random phase also reaches it by chance, because it pulses the acknowledge often while the line toggles. The enable-after-pending case is set up directly: the edge is left waiting for many cycles with the source disabled before the enable is written.

// File: rtl/kwi_pkg.sv
package kwi_pkg;
  localparam int          KWI_ADDR_W      = 16;
  localparam logic [15:0] KWI_VEC_DEFAULT = 16'h3FF8;
  localparam int          KWI_SYNC_DEF    = 2;
  localparam logic        KWI_LINE_IDLE   = 1'b1;
endpackage

// File: rtl/kwi_sync.sv
module kwi_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= IDLE;
        else     chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{IDLE}};
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/kwi_fall_det.sv
module kwi_fall_det #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic fall_o
);
  logic dly_q;

  always_ff @(posedge clk) begin
    if (rst) dly_q <= IDLE;
    else     dly_q <= sync_i;
  end

  // Falling edge: previous value high, present value low.
  assign fall_o = dly_q & ~sync_i;
endmodule

// File: rtl/kwi_pend_flag.sv
module kwi_pend_flag (
  input  logic clk,
  input  logic rst,
  input  logic fall_i,
  input  logic ack_i,
  output logic pend_o
);
  logic pend_q;

  // A new edge wins over a simultaneous acknowledge.
  always_ff @(posedge clk) begin
    if (rst)         pend_q <= 1'b0;
    else if (fall_i) pend_q <= 1'b1;
    else if (ack_i)  pend_q <= 1'b0;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/kwi_cpu_latch.sv
module kwi_cpu_latch #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'h3FF8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pend_i,
  input  logic              en_i,
  input  logic              mask_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic              take_o,
  output logic [ADDR_W-1:0] vec_o
);
  logic req_q;

  // The request is held once latched; only an acknowledge releases it.
  always_ff @(posedge clk) begin
    if (rst)                 req_q <= 1'b0;
    else if (ack_i)          req_q <= 1'b0;
    else if (pend_i && en_i) req_q <= 1'b1;
  end

  assign req_o  = req_q;
  assign take_o = req_q & ~mask_i;
  assign vec_o  = take_o ? VEC_ADDR : '0;
endmodule

// File: rtl/kwi_wake_irq.sv
module kwi_wake_irq
  import kwi_pkg::*;
#(
  parameter int                SYNC_STAGES = KWI_SYNC_DEF,
  parameter int                ADDR_W      = KWI_ADDR_W,
  parameter logic [ADDR_W-1:0] VEC_ADDR    = KWI_VEC_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_n_i,
  input  logic              wake_en_i,
  input  logic              cpu_mask_i,
  input  logic              ack_i,
  output logic              pend_o,
  output logic              irq_req_o,
  output logic              irq_take_o,
  output logic [ADDR_W-1:0] vec_addr_o
);
  logic key_sync;
  logic key_fall;

  kwi_sync #(.STAGES(SYNC_STAGES), .IDLE(KWI_LINE_IDLE)) sync_i (
    .clk(clk), .rst(rst), .d_i(key_n_i), .q_o(key_sync)
  );

  kwi_fall_det #(.IDLE(KWI_LINE_IDLE)) fall_i (
    .clk(clk), .rst(rst), .sync_i(key_sync), .fall_o(key_fall)
  );

  kwi_pend_flag pend_i (
    .clk(clk), .rst(rst), .fall_i(key_fall), .ack_i(ack_i), .pend_o(pend_o)
  );

  kwi_cpu_latch #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) latch_i (
    .clk(clk), .rst(rst), .pend_i(pend_o), .en_i(wake_en_i),
    .mask_i(cpu_mask_i), .ack_i(ack_i), .req_o(irq_req_o),
    .take_o(irq_take_o), .vec_o(vec_addr_o)
  );
endmodule

// File: rtl/kwi_wake_irq_chk.sv
module kwi_wake_irq_chk #(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'h3FF8
) (
  input logic              clk,
  input logic              rst,
  input logic              wake_en_i,
  input logic              cpu_mask_i,
  input logic              ack_i,
  input logic              pend_o,
  input logic              irq_req_o,
  input logic              irq_take_o,
  input logic [ADDR_W-1:0] vec_addr_o
);
  // R3: enabled pending request reaches the latch one edge later
  p_req_follows_r3: assert property (@(posedge clk) disable iff (rst)
    (pend_o && wake_en_i && !ack_i) |=> irq_req_o);

  // R3: a request only rises from an enabled pending flag
  p_req_source_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req_o) |-> ($past(pend_o) && $past(wake_en_i)));

  // R4: pending is kept without acknowledge
  p_pend_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (pend_o && !ack_i) |=> pend_o);

  // R4: disabled source never raises the request
  p_no_req_disabled_r4: assert property (@(posedge clk) disable iff (rst)
    (!wake_en_i && !irq_req_o) |=> !irq_req_o);

  // R6: vector address shown only while taken
  p_vec_taken_r6: assert property (@(posedge clk) disable iff (rst)
    irq_take_o |-> (vec_addr_o == VEC_ADDR));
  p_vec_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !irq_take_o |-> (vec_addr_o == '0));

  // R7: mask blocks the take
  p_mask_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_mask_i |-> !irq_take_o);

  // R8: acknowledge clears the request
  p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
    ack_i |=> !irq_req_o);

  // R11: latched request held until acknowledge
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (irq_req_o && !ack_i) |=> irq_req_o);
endmodule

bind kwi_wake_irq kwi_wake_irq_chk #(.ADDR_W(ADDR_W), .VEC_ADDR(VEC_ADDR)) chk_i (
  .clk(clk), .rst(rst), .wake_en_i(wake_en_i), .cpu_mask_i(cpu_mask_i),
  .ack_i(ack_i), .pend_o(pend_o), .irq_req_o(irq_req_o),
  .irq_take_o(irq_take_o), .vec_addr_o(vec_addr_o)
);

// File: tb/kwi_wake_irq_tb_top.sv
module kwi_wake_irq_tb_top;
  localparam int          STG = 2;
  localparam int          AW  = 16;
  localparam logic [15:0] VEC = 16'h3FF8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_n = 1'b1, en = 1'b0, mask = 1'b0, ack = 1'b0;
  logic pend, req, take;
  logic [AW-1:0] vec;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #5 clk = ~clk;

  kwi_wake_irq #(.SYNC_STAGES(STG), .ADDR_W(AW), .VEC_ADDR(VEC)) dut_i (
    .clk(clk), .rst(rst), .key_n_i(key_n), .wake_en_i(en),
    .cpu_mask_i(mask), .ack_i(ack), .pend_o(pend), .irq_req_o(req),
    .irq_take_o(take), .vec_addr_o(vec)
  );

  // Reference state derived from the requirement latencies
  logic [STG-1:0] m_sh;
  logic m_dly, m_pend, m_req;

  function automatic logic exp_take(input logic r, input logic mk);
    return r & ~mk;
  endfunction
  function automatic logic [AW-1:0] exp_vec(input logic t);
    return t ? VEC : '0;
  endfunction

  task automatic model_step();
    logic fall, np, nr;
    if (rst) begin
      m_sh = '1; m_dly = 1'b1; m_pend = 1'b0; m_req = 1'b0;
    end else begin
      fall = m_dly & ~m_sh[STG-1];
      np   = fall | (m_pend & ~ack);
      nr   = ~ack & (m_req | (m_pend & en));
      m_dly = m_sh[STG-1];
      m_sh  = {m_sh[STG-2:0], key_n};
      m_pend = np; m_req = nr;
    end
  endtask

  task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    chk("R2 pend", {15'd0, pend}, {15'd0, m_pend});
    chk("R3 req",  {15'd0, req},  {15'd0, m_req});
    chk("R6 take", {15'd0, take}, {15'd0, exp_take(m_req, mask)});
    chk("R6 vec",  vec, exp_vec(exp_take(m_req, mask)));
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    model_step();
    ticks(3);
    chk("R1 reset pend", {15'd0, pend}, 16'd0);
    chk("R1 reset req",  {15'd0, req},  16'd0);
    chk("R1 reset vec",  vec, 16'd0);
    @(negedge clk); rst = 1'b0;
    tick();
    chk("R1 post-reset pend", {15'd0, pend}, 16'd0);
    chk("R1 post-reset take", {15'd0, take}, 16'd0);

    // R2/R4: edge while disabled stays pending
    key_n = 1'b0;
    ticks(STG + 1);
    chk("R2 pend after edge", {15'd0, pend}, 16'd1);
    ticks(25);
    chk("R4 pend kept", {15'd0, pend}, 16'd1);
    chk("R4 no req", {15'd0, req}, 16'd0);

    // R5: enable write hands it over one edge later
    en = 1'b1; mask = 1'b1;
    tick();
    chk("R5 req one edge after enable", {15'd0, req}, 16'd1);
    // R7: masked request held
    ticks(6);
    chk("R7 req held masked", {15'd0, req}, 16'd1);
    chk("R7 no take masked", {15'd0, take}, 16'd0);
    mask = 1'b0; #1;
    chk("R7 take on unmask", {15'd0, take}, 16'd1);
    chk("R6 vector", vec, VEC);
    // R11: disabling does not drop a latched request
    en = 1'b0;
    ticks(4);
    chk("R11 req after disable", {15'd0, req}, 16'd1);
    // R8: acknowledge clears
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R8 pend cleared", {15'd0, pend}, 16'd0);
    chk("R8 req cleared", {15'd0, req}, 16'd0);
    // R10: rising edge and steady level
    key_n = 1'b1;
    ticks(8);
    chk("R10 no pend on rise", {15'd0, pend}, 16'd0);
    // R9: edge visible in the acknowledge cycle
    key_n = 1'b0;
    ticks(STG);
    ack = 1'b1; tick(); ack = 1'b0;
    chk("R9 pend survives ack", {15'd0, pend}, 16'd1);
    ack = 1'b1; tick(); ack = 1'b0;
    key_n = 1'b1; ticks(4);

    // Constrained random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 5) == 0) key_n = ~key_n;
      if ($urandom_range(0, 15) == 0) en = ~en;
      if ($urandom_range(0, 9) == 0) mask = ~mask;
      ack = ($urandom_range(0, 7) == 0);
      tick();
    end
    done = 1;
    finish_run();
  end
endmodule